// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block owns the status word of a small processor core together with one saved copy of that word per privileged bank. When an exception request arrives it picks the winner by fixed priority, then updates state in a single clock edge. It redirects the program counter to the vector, writes the return address into the link register of the target bank, saves the old status in that bank and forces the new mode. When a handler returns, it loads the supplied return address and, if asked, copies the bank's saved status back into the live status word.

The core can run in a wide (4-byte) or a compact (2-byte) instruction state. Every entry switches to the wide state. For the two software-visible exceptions the link value is corrected for the compact state, so each handler uses one return offset whatever state it interrupted. A status-write strobe from the decode stage lets software set the status word directly. The register file, decoding and memory access are handled outside this block.

Top module: `exc_ctl`

## Requirements
- R1: While rst_n is low and after it rises, the status word is 8'hD3 (supervisor, both disable flags set, wide state), pc_o is 0, pc_load_o and lr_we_o are 0 and every saved status is 0. Status layout: bit 7 interrupt-disable, bit 6 fast-interrupt-disable, bit 5 compact state, bits 4:0 mode.
- R2: Simultaneous requests resolve as data abort, then fast interrupt, then interrupt, then prefetch abort, then undefined, then software interrupt last.
- R3: An interrupt request is ignored while bit 7 is set, and a fast-interrupt request is ignored while bit 6 is set. A masked request changes no output.
- R4: An entry loads pc_o with the vector: undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, interrupt 0x18, fast interrupt 0x1C. It sets the mode to undefined 5'h1B, supervisor 5'h13 (software interrupt), abort 5'h17 (both aborts), interrupt 5'h12 or fast 5'h11. User mode is 5'h10.
- R5: The link value is pc_i+8 for a data abort and pc_i+4 for prefetch abort, interrupt and fast interrupt. It is pc_i+4 for undefined and software interrupt in the wide state and pc_i+2 in the compact state. It is written with lr_we_o=1 to lr_bank_o: supervisor 0, abort 1, undefined 2, interrupt 3, fast 4.
- R6: On entry the whole previous status word is stored in the target bank's saved status, saved_o[8*bank +: 8].
- R7: On entry the compact bit clears and bit 7 sets. Bit 6 sets on a fast-interrupt entry and otherwise keeps its value.
- R8: A return loads pc_o with ret_addr_i and asserts pc_load_o. With ret_restore_i set, the status word takes the saved status of the current mode's bank. Without it, the status is unchanged.
- R9: A restoring return issued from user mode, which has no bank, leaves the status word unchanged.
- R10: Every result appears on the clock edge that samples the strobe. An exception takes precedence over a return in the same cycle, and a return takes precedence over a status write.
- R11: A status write with no exception or return pending loads stat_wdata_i into the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_und_i | input | 1 | Undefined-instruction request |
| req_swi_i | input | 1 | Software-interrupt request |
| req_pabt_i | input | 1 | Prefetch-abort request |
| req_dabt_i | input | 1 | Data-abort request |
| req_irq_i | input | 1 | Interrupt request |
| req_fiq_i | input | 1 | Fast-interrupt request |
| pc_i | input | ADDR_W | Address of the current instruction |
| ret_valid_i | input | 1 | Handler return strobe |
| ret_restore_i | input | 1 | Return also restores the status word |
| ret_addr_i | input | ADDR_W | Return destination |
| stat_wr_i | input | 1 | Direct status write strobe |
| stat_wdata_i | input | 8 | Status write data |
| pc_o | output | ADDR_W | New program counter |
| pc_load_o | output | 1 | pc_o was reloaded this cycle |
| lr_we_o | output | 1 | Link register write enable |
| lr_bank_o | output | 3 | Bank of the link register write |
| lr_data_o | output | ADDR_W | Link register value |
| stat_o | output | 8 | Current status word |
| saved_o | output | 40 | Saved status words, bank b in bits 8b+7:8b |

## Verification
Every result in this block (vector, link write, saved status, new status, restored status) is due on the first rising edge after the strobe, because one register level lies between the inputs and all outputs. The bench drives each strobe just after a falling edge. It samples one falling edge later, after exactly one rising edge, and then removes the strobe. The pc_load_o and lr_we_o pulses are therefore seen in the only cycle they are high, and a masked request is shown to have no effect in that same cycle.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;
    localparam int STAT_W = 8;
    localparam int MODE_W = 5;
    localparam int NBANK  = 5;
    localparam int BANK_W = $clog2(NBANK);

    localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

    localparam logic [BANK_W-1:0] BANK_SVC = 3'd0;
    localparam logic [BANK_W-1:0] BANK_ABT = 3'd1;
    localparam logic [BANK_W-1:0] BANK_UND = 3'd2;
    localparam logic [BANK_W-1:0] BANK_IRQ = 3'd3;
    localparam logic [BANK_W-1:0] BANK_FIQ = 3'd4;

    typedef struct packed {
        logic              irq_dis;
        logic              fiq_dis;
        logic              cmp;
        logic [MODE_W-1:0] mode;
    } stat_t;

    typedef enum logic [2:0] {
        EX_NONE, EX_UND, EX_SWI, EX_PABT, EX_IRQ, EX_FIQ, EX_DABT
    } exc_e;

    // {has_bank, bank index}
    function automatic logic [BANK_W:0] mode_bank(input logic [MODE_W-1:0] m);
        case (m)
            MODE_SVC: return {1'b1, BANK_SVC};
            MODE_ABT: return {1'b1, BANK_ABT};
            MODE_UND: return {1'b1, BANK_UND};
            MODE_IRQ: return {1'b1, BANK_IRQ};
            MODE_FIQ: return {1'b1, BANK_FIQ};
            default:  return '0;
        endcase
    endfunction
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
    import exc_ctl_pkg::*;
(
    input  logic req_und_i,
    input  logic req_swi_i,
    input  logic req_pabt_i,
    input  logic req_dabt_i,
    input  logic req_irq_i,
    input  logic req_fiq_i,
    input  logic irq_dis_i,
    input  logic fiq_dis_i,
    output exc_e sel_o
);
    logic irq_live, fiq_live;

    always_comb begin
        irq_live = req_irq_i & ~irq_dis_i;
        fiq_live = req_fiq_i & ~fiq_dis_i;
        if      (req_dabt_i) sel_o = EX_DABT;
        else if (fiq_live)   sel_o = EX_FIQ;
        else if (irq_live)   sel_o = EX_IRQ;
        else if (req_pabt_i) sel_o = EX_PABT;
        else if (req_und_i)  sel_o = EX_UND;
        else if (req_swi_i)  sel_o = EX_SWI;
        else                 sel_o = EX_NONE;
    end

    // R3: a masked line never wins
    always_comb begin
        assert_masked_irq_R3: assert (!(sel_o == EX_IRQ && irq_dis_i));
        assert_masked_fiq_R3: assert (!(sel_o == EX_FIQ && fiq_dis_i));
    end
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
    import exc_ctl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  exc_e              sel_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  stat_t             stat_i,
    output logic [ADDR_W-1:0] vec_o,
    output logic [ADDR_W-1:0] link_o,
    output logic [BANK_W-1:0] bank_o,
    output stat_t             stat_o
);
    logic [7:0]        vec8;
    logic [3:0]        off;
    logic [MODE_W-1:0] mode;
    logic              set_fiq;

    always_comb begin
        vec8    = 8'h00;
        off     = 4'd4;
        mode    = stat_i.mode;
        bank_o  = BANK_SVC;
        set_fiq = 1'b0;
        case (sel_i)
            EX_UND:  begin vec8 = 8'h04; mode = MODE_UND; bank_o = BANK_UND;
                           off = stat_i.cmp ? 4'd2 : 4'd4; end
            EX_SWI:  begin vec8 = 8'h08; mode = MODE_SVC; bank_o = BANK_SVC;
                           off = stat_i.cmp ? 4'd2 : 4'd4; end
            EX_PABT: begin vec8 = 8'h0C; mode = MODE_ABT; bank_o = BANK_ABT; end
            EX_DABT: begin vec8 = 8'h10; mode = MODE_ABT; bank_o = BANK_ABT; off = 4'd8; end
            EX_IRQ:  begin vec8 = 8'h18; mode = MODE_IRQ; bank_o = BANK_IRQ; end
            EX_FIQ:  begin vec8 = 8'h1C; mode = MODE_FIQ; bank_o = BANK_FIQ; set_fiq = 1'b1; end
            default: ;
        endcase
        vec_o          = ADDR_W'(vec8);
        link_o         = pc_i + ADDR_W'(off);
        stat_o.mode    = mode;
        stat_o.cmp     = 1'b0;
        stat_o.irq_dis = 1'b1;
        stat_o.fiq_dis = stat_i.fiq_dis | set_fiq;
    end
endmodule

// File: rtl/exc_ctl.sv
module exc_ctl
    import exc_ctl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_und_i,
    input  logic                    req_swi_i,
    input  logic                    req_pabt_i,
    input  logic                    req_dabt_i,
    input  logic                    req_irq_i,
    input  logic                    req_fiq_i,
    input  logic [ADDR_W-1:0]       pc_i,
    input  logic                    ret_valid_i,
    input  logic                    ret_restore_i,
    input  logic [ADDR_W-1:0]       ret_addr_i,
    input  logic                    stat_wr_i,
    input  logic [STAT_W-1:0]       stat_wdata_i,
    output logic [ADDR_W-1:0]       pc_o,
    output logic                    pc_load_o,
    output logic                    lr_we_o,
    output logic [BANK_W-1:0]       lr_bank_o,
    output logic [ADDR_W-1:0]       lr_data_o,
    output logic [STAT_W-1:0]       stat_o,
    output logic [NBANK*STAT_W-1:0] saved_o
);
    localparam stat_t STAT_RST = '{irq_dis: 1'b1, fiq_dis: 1'b1, cmp: 1'b0, mode: MODE_SVC};

    typedef struct packed {
        logic [ADDR_W-1:0]      pc;
        logic                   pc_load;
        logic                   lr_we;
        logic [BANK_W-1:0]      lr_bank;
        logic [ADDR_W-1:0]      lr_data;
        stat_t                  stat;
        stat_t [NBANK-1:0]      saved;
    } st_t;

    st_t st_d, st_q;

    exc_e              sel;
    logic [ADDR_W-1:0] ent_vec, ent_link;
    logic [BANK_W-1:0] ent_bank;
    stat_t             ent_stat;
    logic [BANK_W:0]   cur_bank;

    exc_prio_pick u_pick (
        .req_und_i (req_und_i),
        .req_swi_i (req_swi_i),
        .req_pabt_i(req_pabt_i),
        .req_dabt_i(req_dabt_i),
        .req_irq_i (req_irq_i),
        .req_fiq_i (req_fiq_i),
        .irq_dis_i (st_q.stat.irq_dis),
        .fiq_dis_i (st_q.stat.fiq_dis),
        .sel_o     (sel)
    );

    exc_entry_calc #(.ADDR_W(ADDR_W)) u_calc (
        .sel_i (sel),
        .pc_i  (pc_i),
        .stat_i(st_q.stat),
        .vec_o (ent_vec),
        .link_o(ent_link),
        .bank_o(ent_bank),
        .stat_o(ent_stat)
    );

    always_comb begin
        cur_bank      = mode_bank(st_q.stat.mode);
        st_d          = st_q;
        st_d.pc_load  = 1'b0;
        st_d.lr_we    = 1'b0;
        if (sel != EX_NONE) begin
            st_d.pc              = ent_vec;
            st_d.pc_load         = 1'b1;
            st_d.lr_we           = 1'b1;
            st_d.lr_bank         = ent_bank;
            st_d.lr_data         = ent_link;
            st_d.saved[ent_bank] = st_q.stat;
            st_d.stat            = ent_stat;
        end else if (ret_valid_i) begin
            st_d.pc      = ret_addr_i;
            st_d.pc_load = 1'b1;
            if (ret_restore_i && cur_bank[BANK_W])
                st_d.stat = st_q.saved[cur_bank[BANK_W-1:0]];
        end else if (stat_wr_i) begin
            st_d.stat = stat_t'(stat_wdata_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.stat <= STAT_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o      = st_q.pc;
    assign pc_load_o = st_q.pc_load;
    assign lr_we_o   = st_q.lr_we;
    assign lr_bank_o = st_q.lr_bank;
    assign lr_data_o = st_q.lr_data;
    assign stat_o    = st_q.stat;
    assign saved_o   = st_q.saved;

    assert_entry_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != EX_NONE) |=> (!stat_o[5] && stat_o[7] && pc_load_o && lr_we_o));

    assert_entry_saves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != EX_NONE) |=> (saved_o[lr_bank_o*STAT_W +: STAT_W] == $past(stat_o)));

    assert_return_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_i && sel == EX_NONE) |=> (pc_o == $past(ret_addr_i) && pc_load_o && !lr_we_o));

    assert_user_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_i && ret_restore_i && sel == EX_NONE && stat_o[4:0] == MODE_USR)
        |=> $stable(stat_o));

    assert_link_with_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we_o |-> pc_load_o);
endmodule

// File: tb/tb_exc_ctl.sv
`timescale 1ns/1ps
module tb_exc_ctl;
    localparam int NV = 14;
    // {req fiq,irq,dabt,pabt,swi,und}, cmp, vector, link offset, mode
    localparam logic [23:0] TBL [0:NV-1] = '{
        {6'b000001, 1'b0, 8'h04, 4'd4, 5'h1B},
        {6'b000001, 1'b1, 8'h04, 4'd2, 5'h1B},
        {6'b000010, 1'b0, 8'h08, 4'd4, 5'h13},
        {6'b000010, 1'b1, 8'h08, 4'd2, 5'h13},
        {6'b000100, 1'b1, 8'h0C, 4'd4, 5'h17},
        {6'b001000, 1'b0, 8'h10, 4'd8, 5'h17},
        {6'b001000, 1'b1, 8'h10, 4'd8, 5'h17},
        {6'b010000, 1'b0, 8'h18, 4'd4, 5'h12},
        {6'b100000, 1'b1, 8'h1C, 4'd4, 5'h11},
        {6'b111111, 1'b0, 8'h10, 4'd8, 5'h17},
        {6'b110100, 1'b1, 8'h1C, 4'd4, 5'h11},
        {6'b010101, 1'b0, 8'h18, 4'd4, 5'h12},
        {6'b000111, 1'b1, 8'h0C, 4'd4, 5'h17},
        {6'b000011, 1'b0, 8'h04, 4'd4, 5'h1B}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_und, req_swi, req_pabt, req_dabt, req_irq, req_fiq;
    logic [31:0] pc_in, ret_addr;
    logic ret_valid, ret_restore, stat_wr;
    logic [7:0] stat_wdata;
    logic [31:0] pc_o, lr_data;
    logic pc_load, lr_we;
    logic [2:0] lr_bank;
    logic [7:0] stat_o;
    logic [39:0] saved_o;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    exc_ctl dut (
        .clk(clk), .rst_n(rst_n),
        .req_und_i(req_und), .req_swi_i(req_swi), .req_pabt_i(req_pabt),
        .req_dabt_i(req_dabt), .req_irq_i(req_irq), .req_fiq_i(req_fiq),
        .pc_i(pc_in), .ret_valid_i(ret_valid), .ret_restore_i(ret_restore),
        .ret_addr_i(ret_addr), .stat_wr_i(stat_wr), .stat_wdata_i(stat_wdata),
        .pc_o(pc_o), .pc_load_o(pc_load), .lr_we_o(lr_we), .lr_bank_o(lr_bank),
        .lr_data_o(lr_data), .stat_o(stat_o), .saved_o(saved_o)
    );

    function automatic logic [2:0] bank_of(input logic [4:0] m);
        case (m)
            5'h13: return 3'd0;
            5'h17: return 3'd1;
            5'h1B: return 3'd2;
            5'h12: return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        {req_und, req_swi, req_pabt, req_dabt, req_irq, req_fiq} = '0;
        ret_valid = 0; ret_restore = 0; stat_wr = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic set_reqs(input logic [5:0] r);
        {req_fiq, req_irq, req_dabt, req_pabt, req_swi, req_und} = r;
    endtask

    task automatic wr_stat(input logic [7:0] v);
        stat_wr = 1; stat_wdata = v;
        step();
        chk("R11", "status write", stat_o, v);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        idle();
        pc_in = 0; ret_addr = 0; stat_wdata = 0;
        repeat (3) @(negedge clk);
        chk("R1", "stat in reset", stat_o, 8'hD3);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "stat", stat_o, 8'hD3);
        chk("R1", "pc", pc_o, 0);
        chk("R1", "pc_load", pc_load, 0);
        chk("R1", "lr_we", lr_we, 0);
        chk("R1", "saved", saved_o, 0);

        // table: R2 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  pre;
            logic [4:0]  md;
            logic [31:0] pcv;
            md  = TBL[i][4:0];
            pre = {2'b00, TBL[i][17], 5'h10};
            pcv = 32'h1000 + 32'(i) * 16;
            wr_stat(pre);
            pc_in = pcv; set_reqs(TBL[i][23:18]);
            step();
            chk("R4", "vector", pc_o, 40'(TBL[i][16:9]));
            chk("R10", "pc_load", pc_load, 1);
            chk("R5", "lr_we", lr_we, 1);
            chk("R5", "lr_data", lr_data, 40'(pcv + 32'(TBL[i][8:5])));
            chk("R5", "lr_bank", lr_bank, 40'(bank_of(md)));
            chk("R7", "stat", stat_o, {1'b1, md == 5'h11, 1'b0, md});
            chk("R6", "saved", saved_o[bank_of(md)*8 +: 8], pre);
            ret_valid = 1; ret_restore = 1; ret_addr = pcv + 32'h40;
            step();
            chk("R8", "ret pc", pc_o, 40'(pcv + 32'h40));
            chk("R8", "restored stat", stat_o, pre);
            chk("R8", "no lr on return", lr_we, 0);
        end

        // R3 masking
        wr_stat(8'h90);
        req_irq = 1; step();
        chk("R3", "masked irq lr_we", lr_we, 0);
        chk("R3", "masked irq pc_load", pc_load, 0);
        chk("R3", "masked irq stat", stat_o, 8'h90);
        wr_stat(8'h50);
        req_fiq = 1; step();
        chk("R3", "masked fiq lr_we", lr_we, 0);
        chk("R3", "masked fiq stat", stat_o, 8'h50);
        req_fiq = 1; req_irq = 1; pc_in = 32'h300; step();
        chk("R3", "irq beats masked fiq", pc_o, 32'h18);
        chk("R3", "irq link", lr_data, 32'h304);

        // R7 nested fast interrupt from interrupt mode keeps old status saved
        wr_stat(8'h92);
        req_fiq = 1; pc_in = 32'h400; step();
        chk("R7", "fiq stat", stat_o, 8'hD1);
        chk("R6", "fiq saved", saved_o[4*8 +: 8], 8'h92);

        // R9 restore from user mode
        wr_stat(8'h10);
        ret_valid = 1; ret_restore = 1; ret_addr = 32'h2000; step();
        chk("R9", "user ret pc", pc_o, 32'h2000);
        chk("R9", "user ret stat", stat_o, 8'h10);

        // R8 return without restore
        req_swi = 1; pc_in = 32'h500; step();
        chk("R8", "svc stat", stat_o, 8'h93);
        ret_valid = 1; ret_restore = 0; ret_addr = 32'h504; step();
        chk("R8", "plain ret stat", stat_o, 8'h93);
        chk("R8", "plain ret pc", pc_o, 32'h504);

        // R10 precedence
        ret_valid = 1; ret_restore = 1; stat_wr = 1; stat_wdata = 8'hFF; ret_addr = 32'h600; step();
        chk("R10", "return beats write", stat_o, 8'h10);
        req_und = 1; ret_valid = 1; ret_addr = 32'h700; pc_in = 32'h800; step();
        chk("R10", "entry beats return pc", pc_o, 32'h04);
        chk("R10", "entry beats return lr", lr_we, 1);
        wr_stat(8'h10);
        req_swi = 1; stat_wr = 1; stat_wdata = 8'h3F; step();
        chk("R10", "entry beats write", stat_o, 8'h93);

        finish_run();
    end
endmodule